// File: doc/BRIEF.md
# Next-PC Unit for Jumps and Conditional Branches

This block owns the program counter of a 24-bit processor in which the PC counts instruction words and moves forward by one per instruction. On each cycle that an instruction is presented with `step` high, it decodes the instruction. From that decode it chooses the following PC. The choices are the sequential successor, a PC-relative target from a sign-extended 12-bit or 8-bit displacement, or an absolute target read from a general register. It also raises a one-cycle request to write the return address into register 15 for the linking forms of jump.

Conditional branches test four stored condition flags (negative, zero, overflow, carry) that arrive on a port. The register file sits outside the block. The block names the register it wants on `tgt_sel`, takes its value back on `tgt_data` in the same cycle, and presents the link write on `link_we`/`link_data`. The target is captured at the same edge that requests the link write. For that reason, a linking jump through register 15 goes to the old content of register 15.

Top module: `jump_branch_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0 (parameter `RESET_PC`) and `link_we` is 0.
- R2: At an edge with `step` low, `pc` keeps its value and `link_we` is 0 after that edge.
- R3: Major opcode `instr[23:20]`=0 with sub-opcode `instr[19:16]`=0 sets `pc` to `pc` plus `instr[11:0]` taken as a signed number.
- R4: Major 0, sub 8 sets `pc` to `pc` plus `instr[7:0]` taken as a signed number. Bits 11:8 have no effect.
- R5: `tgt_sel` always equals `instr[15:12]`. Major 0, sub 1 sets `pc` to `tgt_data` and writes no link.
- R6: Major 0 with sub 2 (12-bit displacement), sub A (8-bit displacement) or sub 3 (register target) moves `pc` as R3, R4 and R5 do. For one cycle after the edge, it also drives `link_we`=1 with `link_data` equal to the old `pc`+1.
- R7: For sub 3, the target is the `tgt_data` value seen at the executing edge, before the link write it requests. With `tgt_sel`=15, `pc` therefore takes the old register-15 value.
- R8: Major opcode 8 is a conditional branch whose condition is `instr[18:16]`. The codes are 0 Z set, 1 Z clear, 2 N set, 3 N clear, 4 V set, 5 V clear, 6 C set and 7 C clear. The flags are `flags[3]`=N, `flags[2]`=Z, `flags[1]`=V and `flags[0]`=C. A taken branch sets `pc` to `pc` plus a signed displacement.
- R9: In a branch, `instr[19]`=0 selects the 12-bit displacement `instr[11:0]` and `instr[19]`=1 selects the 8-bit displacement `instr[7:0]`.
- R10: A branch whose condition is false sets `pc` to `pc`+1 and writes no link.
- R11: Every other major opcode, and major 0 with a sub-opcode other than 0, 1, 2, 3, 8 or A, sets `pc` to `pc`+1 with `link_we` 0.
- R12: All PC and link arithmetic wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction on `instr` executes at this edge |
| instr | input | 24 | Instruction word at the current `pc` |
| flags | input | 4 | Stored flags {N, Z, V, C} |
| tgt_sel | output | 4 | Register index requested as jump target |
| tgt_data | input | 24 | Value of the register named by `tgt_sel` |
| pc | output | 24 | Current program counter |
| link_we | output | 1 | Write `link_data` into register 15 |
| link_data | output | 24 | Return address (old PC + 1) |

## Verification
`tgt_sel` is combinational and is checked one time unit after the instruction is driven, before the clock edge. `pc`, `link_we` and `link_data` are each registered once, so they are due right after the first rising edge that sees `step` high. The bench drives inputs on the falling edge and drops `step` just after the rising edge. It compares all three outputs at the following falling edge against a PC model held in the bench. Hold checks let further edges pass with `step` low to confirm that the link request lasts only one cycle.

// File: rtl/jump_branch_unit.sv
module jump_branch_unit #(
  parameter int PC_W = 24,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [23:0]     instr,
  input  logic [3:0]      flags,
  output logic [3:0]      tgt_sel,
  input  logic [PC_W-1:0] tgt_data,
  output logic [PC_W-1:0] pc,
  output logic            link_we,
  output logic [PC_W-1:0] link_data
);
  localparam logic [3:0] GRP_JUMP   = 4'h0;
  localparam logic [3:0] GRP_BRANCH = 4'h8;

  logic [3:0]      major, minor;
  logic [PC_W-1:0] disp, seq_pc, rel_pc, nxt_pc;
  logic            flag_sel, cond_ok, do_link;

  assign major   = instr[23:20];
  assign minor   = instr[19:16];
  assign tgt_sel = instr[15:12];

  assign disp = minor[3] ? {{(PC_W-8){instr[7]}}, instr[7:0]}
                         : {{(PC_W-12){instr[11]}}, instr[11:0]};

  assign seq_pc = pc + 1'b1;
  assign rel_pc = pc + disp;

  always_comb begin
    case (minor[2:1])
      2'd0:    flag_sel = flags[2];
      2'd1:    flag_sel = flags[3];
      2'd2:    flag_sel = flags[1];
      default: flag_sel = flags[0];
    endcase
  end
  assign cond_ok = flag_sel ^ minor[0];

  always_comb begin
    nxt_pc  = seq_pc;
    do_link = 1'b0;
    if (major == GRP_JUMP) begin
      case (minor)
        4'h0, 4'h8: nxt_pc = rel_pc;
        4'h2, 4'hA: begin nxt_pc = rel_pc;   do_link = 1'b1; end
        4'h1:       nxt_pc = tgt_data;
        4'h3:       begin nxt_pc = tgt_data; do_link = 1'b1; end
        default:    nxt_pc = seq_pc;
      endcase
    end else if (major == GRP_BRANCH && cond_ok) begin
      nxt_pc = rel_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= RESET_PC;
      link_we   <= 1'b0;
      link_data <= '0;
    end else begin
      link_we <= step && do_link;
      if (step) begin
        pc <= nxt_pc;
        if (do_link) link_data <= seq_pc;
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(pc) && !link_we));

  a_r5_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
    (step && instr[23:16] == 8'h01) |=> (pc == $past(tgt_data) && !link_we));

  a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    (step && instr[23:20] == 4'h0 && (instr[19:16] == 4'h2 || instr[19:16] == 4'h3 || instr[19:16] == 4'hA))
      |=> (link_we && link_data == $past(pc) + 1'b1));

  a_r11_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    (step && instr[23:20] != 4'h0) |=> !link_we);

  a_r11_other_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (step && instr[23:20] != 4'h0 && instr[23:20] != 4'h8) |=> (pc == $past(pc) + 1'b1));

  a_r7_link_target: assert property (@(posedge clk) disable iff (!rst_n)
    (step && instr[23:16] == 8'h03) |=> (pc == $past(tgt_data)));
endmodule

// File: tb/sim_jump_branch_unit.sv
`timescale 1ns/1ps
module sim_jump_branch_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        step = 0;
  logic [23:0] instr = '0;
  logic [3:0]  flags = '0;
  logic [3:0]  tgt_sel;
  logic [23:0] tgt_data = '0;
  logic [23:0] pc;
  logic        link_we;
  logic [23:0] link_data;

  int checks = 0;
  int failures = 0;
  logic [23:0] model_pc = '0;

  always #10 clk = ~clk;

  jump_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .instr(instr), .flags(flags),
    .tgt_sel(tgt_sel), .tgt_data(tgt_data), .pc(pc),
    .link_we(link_we), .link_data(link_data)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Run one instruction and compare pc and link outputs one edge later.
  task automatic exec(input logic [23:0] i, input logic [3:0] f, input logic [23:0] td,
                      input logic [23:0] exp_pc, input bit exp_link, input string req);
    logic [23:0] old_pc;
    old_pc = model_pc;
    instr = i; flags = f; tgt_data = td; step = 1'b1;
    #1;
    chk(tgt_sel == i[15:12], {req, " R5 tgt_sel"}, {20'h0, tgt_sel}, {20'h0, i[15:12]});
    @(posedge clk); #1; step = 1'b0;
    @(negedge clk);
    chk(pc == exp_pc, {req, " pc"}, pc, exp_pc);
    chk(link_we == exp_link, {req, " link_we"}, {23'h0, link_we}, {23'h0, exp_link});
    if (exp_link)
      chk(link_data == old_pc + 24'd1, {req, " link_data"}, link_data, old_pc + 24'd1);
    model_pc = exp_pc;
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(pc == 24'h0, "R1 reset pc", pc, 24'h0);
    chk(link_we == 1'b0, "R1 reset link_we", {23'h0, link_we}, 24'h0);
    rst_n = 1;
    model_pc = 24'h0;
  endtask

  task automatic t_jump_long;
    exec(24'h000123, 4'h0, 24'h0, 24'h000123, 0, "R3 +0x123");
    exec(24'h000FFF, 4'h0, 24'h0, 24'h000122, 0, "R3 -1");
    exec(24'h000800, 4'h0, 24'h0, 24'hFFF922, 0, "R3 R12 -2048 wrap");
    exec(24'h0007FF, 4'h0, 24'h0, 24'h000121, 0, "R3 R12 +2047 wrap");
  endtask

  task automatic t_jump_short;
    exec(24'h080A10, 4'h0, 24'h0, 24'h000131, 0, "R4 +0x10 high bits ignored");
    exec(24'h0805F0, 4'h0, 24'h0, 24'h000121, 0, "R4 -0x10");
  endtask

  task automatic t_reg_jump;
    exec(24'h015ABC, 4'h0, 24'h456789, 24'h456789, 0, "R5 register jump");
  endtask

  task automatic t_links;
    exec(24'h020010, 4'h0, 24'h0, 24'h456799, 1, "R6 link long");
    exec(24'h0A00F0, 4'h0, 24'h0, 24'h456789, 1, "R6 link short");
    exec(24'h03F000, 4'h0, 24'h00ABCD, 24'h00ABCD, 1, "R7 link via r15");
    chk(link_data == 24'h45678A, "R7 link value after jump", link_data, 24'h45678A);
  endtask

  task automatic t_hold;
    instr = 24'h000123; step = 0;
    repeat (3) begin
      @(negedge clk);
      chk(pc == model_pc, "R2 hold pc", pc, model_pc);
      chk(link_we == 1'b0, "R2 hold link_we", {23'h0, link_we}, 24'h0);
    end
  endtask

  function automatic bit want_taken(input logic [2:0] c, input logic [3:0] f);
    case (c)
      3'd0: return f[2];
      3'd1: return !f[2];
      3'd2: return f[3];
      3'd3: return !f[3];
      3'd4: return f[1];
      3'd5: return !f[1];
      3'd6: return f[0];
      default: return !f[0];
    endcase
  endfunction

  task automatic t_branches;
    logic [3:0] pats [6] = '{4'b0000, 4'b1111, 4'b1000, 4'b0100, 4'b0010, 4'b0001};
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 6; p++) begin
        logic [23:0] e;
        logic [3:0] sb;
        sb = 4'(s);
        if (want_taken(sb[2:0], pats[p]))
          e = sb[3] ? model_pc - 24'h40 : model_pc + 24'hC0;
        else
          e = model_pc + 24'd1;
        exec({4'h8, sb, 4'h3, 12'h0C0}, pats[p], 24'h0, e, 0,
             sb[3] ? "R8 R9 R10 short branch" : "R8 R9 R10 long branch");
      end
    end
  endtask

  task automatic t_other;
    for (int o = 1; o < 16; o++) begin
      if (o != 8)
        exec({4'(o), 4'h2, 16'hF123}, 4'hF, 24'h777777, model_pc + 24'd1, 0, "R11 other major");
    end
    for (int s = 4; s < 16; s++) begin
      if (s != 8 && s != 10)
        exec({4'h0, 4'(s), 16'h5123}, 4'hF, 24'h777777, model_pc + 24'd1, 0, "R11 unused jump sub");
    end
  endtask

  task automatic t_wrap;
    exec(24'h012000, 4'h0, 24'hFFFFFF, 24'hFFFFFF, 0, "R12 setup");
    exec(24'h400000, 4'h0, 24'h0, 24'h000000, 0, "R12 seq wrap");
    exec(24'h013000, 4'h0, 24'hFFFFFF, 24'hFFFFFF, 0, "R12 setup2");
    exec(24'h020005, 4'h0, 24'h0, 24'h000004, 1, "R12 link wrap");
    chk(link_data == 24'h000000, "R12 link_data wraps", link_data, 24'h000000);
  endtask

  initial begin
    #(20ns * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=%h expected=%h", 24'h1, 24'h0);
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_jump_long();
    t_jump_short();
    t_reg_jump();
    t_links();
    t_hold();
    t_branches();
    t_other();
    t_wrap();
    t_hold();
    summary();
    $finish;
  end
endmodule